// File: doc/BRIEF.md
# Shared Timer/Watchdog Prescaler

This block holds an 8-bit timer counter, a watchdog base counter and one prescaler counter that both of them compete for. A control byte, written over a simple register bus, decides which of the two owns the prescaler, what divide ratio it applies, whether the timer is clocked by the internal instruction tick or by edges on an asynchronous external pin, and which pin edge counts. The consumer that does not own the prescaler runs undivided. So the timer counts every selected clock event, and the watchdog raises a timeout on every wrap of its base counter.

When the timer wraps from its all-ones value it raises a sticky overflow flag, which stays set until the clear input is pulsed. When the watchdog chain expires and the watchdog is enabled, a one-cycle timeout pulse is produced. Software can load the timer value over the bus, and any such load also empties the prescaler. A watchdog-clear input restarts the watchdog base counter. It empties the prescaler only while the watchdog owns it.

Top module: `tmr_wdt_prescaler`

## Requirements
- R1: After reset the timer value, the control byte and the overflow flag read 0, and no timeout pulse is produced.
- R2: A write with `wr_sel`=0 loads the control byte, whose layout is: bits 2:0 ratio code, bit 3 ownership (1 = watchdog), bit 4 edge select (1 = falling), bit 5 source select (1 = external pin). Bits 7:6 read as 0.
- R3: While the timer owns the prescaler, the timer advances once every 2^(code+1) selected clock events, so codes 0..7 give 1:2 up to 1:256.
- R4: While the watchdog owns the prescaler, the timer advances on every selected clock event, and a timeout occurs once every 2^code watchdog base wraps (1:1 up to 1:128).
- R5: While the timer owns the prescaler, the watchdog times out on every wrap of its base counter, which is once per 2^WDT_W internal ticks.
- R6: With source select 0 the timer clock is `tick_en` and the pin is ignored. With source select 1 the timer clock is the selected pin edge and `tick_en` is ignored.
- R7: A pin transition of the selected polarity advances the timer on the third rising clock edge after the transition, and a transition of the other polarity does nothing.
- R8: A timer advance from 0xFF wraps to 0x00 and sets the overflow flag. The flag stays set until `tov_clr` is pulsed, and a set in the same cycle wins over the clear.
- R9: A write with `wr_sel`=1 loads the timer value and empties the prescaler, whichever consumer owns it.
- R10: `wdt_clr` restarts the watchdog base counter in every mode. It empties the prescaler only while the watchdog owns it.
- R11: With `wdt_en` low no timeout pulse is produced.
- R12: Each timeout is a pulse exactly one clock cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Internal instruction-clock enable, also the watchdog base tick |
| ext_pin | input | 1 | Asynchronous external timer clock pin |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control byte, 1 timer value |
| wr_data | input | DATA_W | Write data |
| tov_clr | input | 1 | Clears the overflow flag |
| wdt_en | input | 1 | Lets watchdog expiry produce a timeout |
| wdt_clr | input | 1 | Restarts the watchdog chain |
| ctrl_out | output | DATA_W | Control byte read-back |
| count_out | output | DATA_W | Timer value read-back |
| tov_flag | output | 1 | Sticky timer overflow flag |
| wdt_timeout | output | 1 | One-cycle watchdog timeout pulse |

## Verification
The properties assume that `wr_sel` is meaningful whenever `wr_en` is high and that the watchdog base counter is at least two bits wide, so two expiries can never fall on adjacent cycles. They also assume that a timer step can only come from the clock event of the current mode. The stimulus keeps `tick_en` low during every bus write and every clear pulse, so each expected count follows directly from the number of ticks driven. Each pin transition is held for at least four cycles, so the two-stage synchronizer always sees a settled level.

// File: rtl/tp_pkg.sv
package tp_pkg;
   typedef enum logic {
      SEL_CTRL  = 1'b0,
      SEL_COUNT = 1'b1
   } tp_sel_e;

   // control byte bit positions, derived from the ratio field width
   function automatic int assign_bit(input int ratio_w);
      return ratio_w;
   endfunction
   function automatic int edge_bit(input int ratio_w);
      return ratio_w + 1;
   endfunction
   function automatic int src_bit(input int ratio_w);
      return ratio_w + 2;
   endfunction
   function automatic int ctrl_bits(input int ratio_w);
      return ratio_w + 3;
   endfunction
endpackage

// File: rtl/tp_pin_sync.sv
module tp_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic fall_sel,
   output logic edge_pulse
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tp_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sr;
   logic              last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '0;
         last <= 1'b0;
      end else begin
         sr   <= {sr[STAGES-2:0], pin};
         last <= sr[STAGES-1];
      end
   end

   // a change of the settled level whose new value matches the polarity
   assign edge_pulse = (sr[STAGES-1] != last) && (sr[STAGES-1] ^ fall_sel);
endmodule

// File: rtl/tp_divider.sv
module tp_divider #(
   parameter int PRE_W   = 8,
   parameter int RATIO_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               evt,
   input  logic [RATIO_W-1:0] ratio,
   input  logic               to_wdt,
   output logic               tap_out
);
   localparam int IDX_W = $clog2(PRE_W + 1);

   generate
      if (PRE_W < (1 << RATIO_W)) begin : g_bad_width
         $error("tp_divider: PRE_W too small for the ratio field");
      end
   endgenerate

   logic [PRE_W-1:0] cnt;
   logic [PRE_W:0]   full;
   logic [IDX_W-1:0] idx;

   assign full[0] = 1'b1;
   generate
      for (genvar k = 1; k <= PRE_W; k++) begin : g_tap
         assign full[k] = &cnt[k-1:0];
      end
   endgenerate

   // the timer sees one extra halving compared with the watchdog
   assign idx     = IDX_W'(ratio) + IDX_W'(!to_wdt);
   assign tap_out = evt && !clr && full[idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (evt) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/tp_wdt_base.sv
module tp_wdt_base #(
   parameter int W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic clr,
   output logic ovf
);
   generate
      if (W < 2) begin : g_bad_w
         $error("tp_wdt_base: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt;

   assign ovf = tick && !clr && (&cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/tmr_wdt_prescaler.sv
module tmr_wdt_prescaler
   import tp_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int PRE_W       = 8,
   parameter int RATIO_W     = 3,
   parameter int WDT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              ext_pin,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tov_clr,
   input  logic              wdt_en,
   input  logic              wdt_clr,
   output logic [DATA_W-1:0] ctrl_out,
   output logic [DATA_W-1:0] count_out,
   output logic              tov_flag,
   output logic              wdt_timeout
);
   localparam int CB     = ctrl_bits(RATIO_W);
   localparam int B_ASGN = assign_bit(RATIO_W);
   localparam int B_EDGE = edge_bit(RATIO_W);
   localparam int B_SRC  = src_bit(RATIO_W);

   generate
      if (CB >= DATA_W) begin : g_bad_bus
         $error("tmr_wdt_prescaler: control byte does not fit the bus");
      end
   endgenerate

   logic [CB-1:0]     ctrl_r;
   logic [DATA_W-1:0] count_r;
   logic              flag_r, to_r;
   logic              wr_ctrl, wr_tmr;
   logic              pin_evt, tmr_evt, wdt_ovf;
   logic              presc_in, presc_clr, presc_tap;
   logic              tmr_inc, wdt_evt, to_wdt;

   assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
   assign wr_tmr  = wr_en && (wr_sel == SEL_COUNT);
   assign to_wdt  = ctrl_r[B_ASGN];

   tp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin       (ext_pin),
      .fall_sel  (ctrl_r[B_EDGE]),
      .edge_pulse(pin_evt)
   );

   tp_wdt_base #(.W(WDT_W)) u_wdt (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick_en),
      .clr  (wdt_clr),
      .ovf  (wdt_ovf)
   );

   assign tmr_evt   = ctrl_r[B_SRC] ? pin_evt : tick_en;
   assign presc_in  = to_wdt ? wdt_ovf : tmr_evt;
   assign presc_clr = wr_tmr || (wdt_clr && to_wdt);

   tp_divider #(.PRE_W(PRE_W), .RATIO_W(RATIO_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (presc_clr),
      .evt    (presc_in),
      .ratio  (ctrl_r[RATIO_W-1:0]),
      .to_wdt (to_wdt),
      .tap_out(presc_tap)
   );

   assign tmr_inc = !wr_tmr && (to_wdt ? tmr_evt : presc_tap);
   assign wdt_evt = to_wdt ? presc_tap : wdt_ovf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_r  <= '0;
         count_r <= '0;
         flag_r  <= 1'b0;
         to_r    <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_r <= wr_data[CB-1:0];
         if (wr_tmr)       count_r <= wr_data;
         else if (tmr_inc) count_r <= count_r + 1'b1;
         if (tmr_inc && (&count_r)) flag_r <= 1'b1;
         else if (tov_clr)          flag_r <= 1'b0;
         to_r <= wdt_evt && wdt_en;
      end
   end

   assign ctrl_out    = DATA_W'(ctrl_r);
   assign count_out   = count_r;
   assign tov_flag    = flag_r;
   assign wdt_timeout = to_r;
endmodule

// File: rtl/tmr_wdt_prescaler_chk.sv
module tmr_wdt_prescaler_chk #(
   parameter int DATA_W = 8,
   parameter int CB     = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wr_sel,
   input logic [DATA_W-1:0] wr_data,
   input logic              tov_clr,
   input logic              wdt_en,
   input logic [CB-1:0]     ctrl_lo,
   input logic [DATA_W-1:0] count_out,
   input logic              tov_flag,
   input logic              wdt_timeout
);
   AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel) |=> (ctrl_lo == $past(wr_data[CB-1:0]))); // R2

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel) |=> ((count_out == $past(count_out)) ||
                              (count_out == $past(count_out) + DATA_W'(1)))); // R3

   AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ((count_out == '0) && ($past(count_out) == '1) && !$past(wr_en && wr_sel))
      |-> tov_flag); // R8

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (tov_flag && !tov_clr) |=> tov_flag); // R8

   AST_TIMER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel) |=> (count_out == $past(wr_data))); // R9

   AST_TO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_timeout |-> $past(wdt_en)); // R11

   AST_TO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_timeout |=> !wdt_timeout); // R12
endmodule

bind tmr_wdt_prescaler tmr_wdt_prescaler_chk #(.DATA_W(DATA_W), .CB(CB)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_sel     (wr_sel),
   .wr_data    (wr_data),
   .tov_clr    (tov_clr),
   .wdt_en     (wdt_en),
   .ctrl_lo    (ctrl_out[CB-1:0]),
   .count_out  (count_out),
   .tov_flag   (tov_flag),
   .wdt_timeout(wdt_timeout)
);

// File: tb/tb_tmr_wdt_prescaler.sv
module tb_tmr_wdt_prescaler;
   localparam int K_CNT = 0, K_FLAG = 1, K_CTRL = 2, K_TO = 3;

   typedef struct {
      string req;
      int    kind;
      int    exp;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0, ext_pin = 1'b0;
   logic       wr_en = 1'b0, wr_sel = 1'b0;
   logic [7:0] wr_data = '0;
   logic       tov_clr = 1'b0, wdt_en = 1'b0, wdt_clr = 1'b0;
   logic [7:0] ctrl_out, count_out;
   logic       tov_flag, wdt_timeout;

   item_t q[$];
   item_t it;
   int    act;
   int    n_cmp = 0, n_bad = 0, to_seen = 0, exp_to = 0;
   bit    done = 1'b0;

   always #2 clk = ~clk;

   tmr_wdt_prescaler #(.WDT_W(4)) dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ext_pin(ext_pin),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .tov_clr(tov_clr),
      .wdt_en(wdt_en), .wdt_clr(wdt_clr), .ctrl_out(ctrl_out),
      .count_out(count_out), .tov_flag(tov_flag), .wdt_timeout(wdt_timeout)
   );

   // monitor: counts timeout pulses and drains the expectation queue
   always @(negedge clk) begin
      if (rst_n && wdt_timeout) to_seen++;
      while (q.size() > 0) begin
         it = q.pop_front();
         case (it.kind)
            K_CNT:   act = int'(count_out);
            K_FLAG:  act = int'(tov_flag);
            K_CTRL:  act = int'(ctrl_out);
            default: act = to_seen;
         endcase
         n_cmp++;
         if (act != it.exp) begin
            n_bad++;
            $display("FAIL %s kind %0d: actual %0d expected %0d", it.req, it.kind, act, it.exp);
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic push(input string req, input int kind, input int exp);
      item_t x;
      x.req = req; x.kind = kind; x.exp = exp;
      q.push_back(x);
   endtask

   task automatic expect_v(input string req, input int kind, input int exp);
      idle(4);
      push(req, kind, exp);
   endtask

   task automatic tick(input int n);
      @(posedge clk); #1 tick_en = 1'b1;
      repeat (n) @(posedge clk);
      #1 tick_en = 1'b0;
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      @(posedge clk); #1 wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(posedge clk); #1 wr_en = 1'b0;
   endtask

   task automatic pulse_wdt_clr();
      @(posedge clk); #1 wdt_clr = 1'b1;
      @(posedge clk); #1 wdt_clr = 1'b0;
   endtask

   task automatic pulse_tov_clr();
      @(posedge clk); #1 tov_clr = 1'b1;
      @(posedge clk); #1 tov_clr = 1'b0;
   endtask

   task automatic pin_set(input logic v);
      @(posedge clk); #1 ext_pin = v;
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      // R1 reset state
      expect_v("R1", K_CNT, 0);
      push("R1", K_FLAG, 0);
      push("R1", K_CTRL, 0);
      push("R1", K_TO, 0);

      // R2 control layout, upper bits read zero
      wr(1'b0, 8'hFF);
      expect_v("R2", K_CTRL, 8'h3F);
      wr(1'b0, 8'h00);

      // R3 timer-owned divide ratios
      wr(1'b1, 8'd0); tick(10);  expect_v("R3", K_CNT, 5);
      wr(1'b0, 8'h03); wr(1'b1, 8'd0); tick(64); expect_v("R3", K_CNT, 4);
      wr(1'b0, 8'h07); wr(1'b1, 8'd0); tick(511); expect_v("R3", K_CNT, 1);
      tick(1); expect_v("R3", K_CNT, 2);

      // R9 timer write empties the prescaler
      wr(1'b0, 8'h01); wr(1'b1, 8'd0); tick(3); expect_v("R9", K_CNT, 0);
      wr(1'b1, 8'd10); tick(1); expect_v("R9", K_CNT, 10);
      tick(3); expect_v("R9", K_CNT, 11);

      // R10 watchdog clear keeps a timer-owned prescaler
      wr(1'b1, 8'd0); tick(3); pulse_wdt_clr(); tick(1);
      expect_v("R10", K_CNT, 1);

      // R4 watchdog-owned: timer undivided
      wr(1'b0, 8'h0B); wr(1'b1, 8'd0); tick(5); expect_v("R4", K_CNT, 5);

      // R8 wrap and sticky flag
      wr(1'b1, 8'hFE); tick(1); expect_v("R8", K_CNT, 8'hFF); push("R8", K_FLAG, 0);
      tick(1); expect_v("R8", K_CNT, 0); push("R8", K_FLAG, 1);
      tick(3); expect_v("R8", K_FLAG, 1);
      pulse_tov_clr(); expect_v("R8", K_FLAG, 0);

      // R6 / R7 external pin, rising edge, latency of three edges
      wr(1'b0, 8'h28); wr(1'b1, 8'd0);
      pin_set(1'b1);
      repeat (2) @(posedge clk);
      #1 push("R7 before third edge", K_CNT, 0);
      @(posedge clk);
      #1 push("R7 at third edge", K_CNT, 1);
      tick(6); expect_v("R6 tick ignored on pin source", K_CNT, 1);
      wr(1'b0, 8'h38); pin_set(1'b0); expect_v("R7 falling edge counts", K_CNT, 2);
      pin_set(1'b1); expect_v("R7 rising ignored in falling mode", K_CNT, 2);
      wr(1'b0, 8'h28); pin_set(1'b0); expect_v("R7 falling ignored in rising mode", K_CNT, 2);
      pin_set(1'b1); expect_v("R7 rising edge counts", K_CNT, 3);
      wr(1'b0, 8'h08); pin_set(1'b0); idle(4); pin_set(1'b1);
      expect_v("R6 pin ignored on internal source", K_CNT, 3);

      // R4 watchdog ratio 1:4 on base wraps of 16 ticks
      wdt_en = 1'b1;
      wr(1'b0, 8'h0A); pulse_wdt_clr();
      tick(63); expect_v("R4", K_TO, exp_to);
      tick(1);  exp_to++; expect_v("R4", K_TO, exp_to);
      tick(63); expect_v("R4", K_TO, exp_to);
      tick(1);  exp_to++; expect_v("R4", K_TO, exp_to);
      // R4 1:1 at code 0, R12 one cycle per timeout
      wr(1'b0, 8'h08); pulse_wdt_clr();
      tick(16); exp_to++; expect_v("R12", K_TO, exp_to);

      // R5 timer-owned: undivided watchdog
      wr(1'b0, 8'h00); pulse_wdt_clr();
      tick(15); expect_v("R5", K_TO, exp_to);
      tick(1);  exp_to++; expect_v("R5", K_TO, exp_to);

      // R10 clear restarts base counter
      tick(10); pulse_wdt_clr(); tick(15); expect_v("R10", K_TO, exp_to);
      tick(1); exp_to++; expect_v("R10", K_TO, exp_to);

      // R11 disabled watchdog
      wdt_en = 1'b0;
      tick(32); expect_v("R11", K_TO, exp_to);

      idle(4);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run hung, actual 0 expected 1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule